// File: doc/BRIEF.md
# TDM Receive Slot Selector

This block takes a time-division-multiplexed serial audio stream on two data lines and extracts four channel samples per frame. A frame is sixteen 32-bit slots long on each line and is marked by a frame-sync pulse. Only the upper 24 bits of each slot are audio; the low byte is padding. A 3-bit source code picks one data line and one group of four consecutive slots on that line, and those four slots become output channels 1 to 4.

The block runs in the bit-clock domain. It counts bits from the frame-sync edge and shifts the selected bits into four staging registers. When the last bit of the frame has been taken, it copies the four samples to the output together with a one-cycle valid strobe. The source code is latched only when a frame starts. A frame sync that comes early restarts the count and drops the unfinished frame.

Top module: `tdm_slot_router`

## Requirements
- R1: While reset is asserted and until the first complete frame, `smp_valid` is 0 and `smp_out` is all zeros.
- R2: Each slot is 32 bits and is sent MSB first. Slot bits 31..8 form the 24-bit sample, with bit 31 as the sample MSB. Slot bits 7..0 have no effect on any output.
- R3: Source codes 0, 1, 2 and 3 take slots 1-4, 5-8, 9-12 and 13-16 of data line `sdata[0]`.
- R4: Source codes 4, 5, 6 and 7 take slots 1-4, 5-8, 9-12 and 13-16 of data line `sdata[1]`.
- R5: Within the selected group, the k-th slot (k = 0..3) goes to channel k+1, which is `smp_out[24k+23:24k]`.
- R6: A frame starts on the first rising clock edge at which `fsync` is seen high after being low. Frame bit i (0..511, slot i/32, slot bit 31-i%32) is sampled on the (i+1)-th rising edge after that edge. `smp_valid` is high for exactly the one cycle that follows the edge sampling bit 511, and `smp_out` changes only in that cycle.
- R7: A source code applied after a frame has started has no effect on that frame. It is used from the next frame start onward.
- R8: A new `fsync` rise seen before bit 511 has been sampled discards the partial frame without a valid strobe and starts a new frame from that edge.
- R9: An `fsync` rise on the same edge as bit 511 completes the current frame and starts the next frame. After an idle gap with `fsync` low, the next rise also starts a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fsync | input | 1 | Frame sync; a rise marks the edge just before bit 0 |
| sdata | input | 2 | Serial data lines; bit 0 is line 1, bit 1 is line 2 |
| src_sel | input | 3 | Source code: bit 2 selects the line, bits 1..0 select the slot group |
| smp_out | output | 96 | Four 24-bit samples; channel 1 is in the low bits |
| smp_valid | output | 1 | One-cycle strobe when `smp_out` holds a new frame |

## Verification
The only result is the sample word and its strobe. Both are due 513 rising edges after the edge that first sees `fsync` high, which is one edge after bit 511 is sampled. The bench drives inputs on falling edges and records the cycle count at which it raises `fsync`. It queues that count plus 513 with the expected samples, computed from the slot data and the source code that was present at the frame start. A falling-edge monitor compares the outputs in exactly that cycle. Any strobe in another cycle is a failure, which covers discarded partial frames and mid-frame code changes.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  localparam int DEF_SLOT_W   = 32;
  localparam int DEF_SAMPLE_W = 24;
  localparam int DEF_SLOTS    = 16;
  localparam int DEF_NUM_CH   = 4;
  localparam int DEF_LINES    = 2;

  typedef enum logic [0:0] {
    FR_IDLE = 1'b0,
    FR_RUN  = 1'b1
  } fr_state_e;

endpackage

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter
  import tdm_rx_pkg::*;
#(
  parameter int FRAME_BITS = 512,
  parameter int CNT_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic             frame_start,
  output logic             bit_en,
  output logic [CNT_W-1:0] bit_idx,
  output logic             frame_done
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  fr_state_e        state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             fs_d_q;

  // frame boundary and progress decode
  always_comb begin
    frame_start = fsync & ~fs_d_q;
    bit_en      = (state_q == FR_RUN);
    frame_done  = bit_en && (cnt_q == LAST_IDX);
    bit_idx     = cnt_q;
  end

  // next-state
  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    if (frame_start) begin
      state_n = FR_RUN;
      cnt_n   = '0;
    end else if (frame_done) begin
      state_n = FR_IDLE;
      cnt_n   = '0;
    end else if (bit_en) begin
      cnt_n   = cnt_q + CNT_W'(1);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      fs_d_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      fs_d_q  <= fsync;
    end
  end

  // R6
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bit_en && bit_idx == '0));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !frame_done && !frame_start) |=> (bit_en && bit_idx == $past(bit_idx) + CNT_W'(1)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_start) |=> !bit_en);

endmodule

// File: rtl/tdm_slot_capture.sv
module tdm_slot_capture #(
  parameter int NUM_LINES = 2,
  parameter int SLOTS     = 16,
  parameter int SLOT_W    = 32,
  parameter int SAMPLE_W  = 24,
  parameter int NUM_CH    = 4,
  parameter int CNT_W     = 9,
  parameter int SEL_W     = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_start,
  input  logic                         bit_en,
  input  logic [CNT_W-1:0]             bit_idx,
  input  logic [NUM_LINES-1:0]         sdata,
  input  logic [SEL_W-1:0]             src_sel,
  output logic [NUM_CH*SAMPLE_W-1:0]   stage_flat
);

  localparam int SLOT_BW    = $clog2(SLOT_W);
  localparam int SLOT_IDX_W = CNT_W - SLOT_BW;
  localparam int GROUPS     = SLOTS / NUM_CH;
  localparam int GRP_W      = $clog2(GROUPS);
  localparam int CH_W       = $clog2(NUM_CH);
  localparam int LINE_W     = SEL_W - GRP_W;
  localparam logic [SLOT_BW-1:0] SAMP_LIM = SLOT_BW'(SAMPLE_W);

  logic [SEL_W-1:0]      sel_q, sel_n;
  logic [SLOT_IDX_W-1:0] slot_idx;
  logic [SLOT_BW-1:0]    bpos;
  logic [GRP_W-1:0]      grp_of;
  logic [CH_W-1:0]       ch_of;
  logic [LINE_W-1:0]     line_of;
  logic                  in_group;
  logic                  din;

  // position decode and line pick
  always_comb begin
    slot_idx = bit_idx[CNT_W-1:SLOT_BW];
    bpos     = bit_idx[SLOT_BW-1:0];
    grp_of   = slot_idx[SLOT_IDX_W-1:CH_W];
    ch_of    = slot_idx[CH_W-1:0];
    line_of  = sel_q[SEL_W-1:GRP_W];
    din      = sdata[line_of];
    in_group = bit_en && (grp_of == sel_q[GRP_W-1:0]) && (bpos < SAMP_LIM);
    sel_n    = frame_start ? src_sel : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_n;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] stage_q, stage_n;
    logic                shift_en;

    always_comb begin
      shift_en = in_group && (ch_of == CH_W'(c));
      stage_n  = shift_en ? {stage_q[SAMPLE_W-2:0], din} : stage_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
      end else begin
        stage_q <= stage_n;
      end
    end

    assign stage_flat[c*SAMPLE_W +: SAMPLE_W] = stage_q;
  end

  // R2
  pad_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && bpos >= SAMP_LIM) |=> $stable(stage_flat));

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(sel_q));

endmodule

// File: rtl/tdm_out_stage.sv
module tdm_out_stage #(
  parameter int OUT_W = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic [OUT_W-1:0] stage_flat,
  output logic [OUT_W-1:0] smp_out,
  output logic             smp_valid
);

  logic [OUT_W-1:0] data_q, data_n;
  logic             vld_q;

  always_comb begin
    data_n = frame_done ? stage_flat : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      vld_q  <= frame_done;
    end
  end

  assign smp_out   = data_q;
  assign smp_valid = vld_q;

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  // R6
  data_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(smp_out) |-> smp_valid);

endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_W    = DEF_SLOT_W,
  parameter int SAMPLE_W  = DEF_SAMPLE_W,
  parameter int SLOTS     = DEF_SLOTS,
  parameter int NUM_CH    = DEF_NUM_CH,
  parameter int NUM_LINES = DEF_LINES,
  parameter int SEL_W     = $clog2(NUM_LINES) + $clog2(SLOTS / NUM_CH),
  parameter int OUT_W     = NUM_CH * SAMPLE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fsync,
  input  logic [NUM_LINES-1:0] sdata,
  input  logic [SEL_W-1:0]     src_sel,
  output logic [OUT_W-1:0]     smp_out,
  output logic                 smp_valid
);

  localparam int FRAME_BITS = SLOTS * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  logic             frame_start;
  logic             bit_en;
  logic [CNT_W-1:0] bit_idx;
  logic             frame_done;
  logic [OUT_W-1:0] stage_flat;

  tdm_frame_counter #(
    .FRAME_BITS (FRAME_BITS),
    .CNT_W      (CNT_W)
  ) i_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsync       (fsync),
    .frame_start (frame_start),
    .bit_en      (bit_en),
    .bit_idx     (bit_idx),
    .frame_done  (frame_done)
  );

  tdm_slot_capture #(
    .NUM_LINES (NUM_LINES),
    .SLOTS     (SLOTS),
    .SLOT_W    (SLOT_W),
    .SAMPLE_W  (SAMPLE_W),
    .NUM_CH    (NUM_CH),
    .CNT_W     (CNT_W),
    .SEL_W     (SEL_W)
  ) i_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .bit_en      (bit_en),
    .bit_idx     (bit_idx),
    .sdata       (sdata),
    .src_sel     (src_sel),
    .stage_flat  (stage_flat)
  );

  tdm_out_stage #(
    .OUT_W (OUT_W)
  ) i_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .stage_flat (stage_flat),
    .smp_out    (smp_out),
    .smp_valid  (smp_valid)
  );

  // R8
  early_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && bit_en && !frame_done) |=> !smp_valid);

endmodule

// File: tb/test_tdm_slot_router.sv
module test_tdm_slot_router;

  localparam int FRAME_BITS = 512;
  localparam int OUT_W      = 96;

  typedef struct {
    int             cyc;
    logic [OUT_W-1:0] d;
    string          tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             fsync;
  logic [1:0]       sdata;
  logic [2:0]       src_sel;
  logic [OUT_W-1:0] smp_out;
  logic             smp_valid;

  int   cyc = 0;
  int   n_checks = 0;
  int   n_fails = 0;
  bit   mon_on = 1'b0;
  exp_t eq[$];

  logic [31:0] fd [2][16];
  int          st_cyc;
  logic [2:0]  st_sel;

  tdm_slot_router i_tdm_slot_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .sdata     (sdata),
    .src_sel   (src_sel),
    .smp_out   (smp_out),
    .smp_valid (smp_valid)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [OUT_W-1:0] exp_word(input logic [2:0] sel);
    logic [OUT_W-1:0] w;
    w = '0;
    for (int k = 0; k < 4; k++) begin
      w[k*24 +: 24] = fd[sel[2]][int'(sel[1:0]) * 4 + k][31:8];
    end
    return w;
  endfunction

  task automatic fill_random();
    for (int l = 0; l < 2; l++)
      for (int s = 0; s < 16; s++)
        fd[l][s] = $urandom;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // frame-sync rise for a frame started from idle
  task automatic pulse_fs();
    @(negedge clk);
    fsync  = 1'b1;
    sdata  = 2'($urandom);
    st_cyc = cyc;
    st_sel = src_sel;
  endtask

  // drive nbits frame bits; optionally raise fsync on the last bit
  task automatic body(input int nbits, input bit fs_end, input int chg_at,
                      input logic [2:0] chg_sel, input string tag);
    if (nbits == FRAME_BITS) begin
      eq.push_back('{cyc: st_cyc + FRAME_BITS + 1, d: exp_word(st_sel), tag: tag});
    end
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      if (i == chg_at) src_sel = chg_sel;
      for (int l = 0; l < 2; l++) sdata[l] = fd[l][i / 32][31 - (i % 32)];
      fsync = fs_end && (i == nbits - 1);
      if (fsync) begin
        st_cyc = cyc;
        st_sel = src_sel;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fsync = 1'b0;
      sdata = 2'($urandom);
    end
  endtask

  // output monitor: result due exactly at the recorded cycle (R6)
  always @(negedge clk) begin
    if (mon_on) begin
      if (eq.size() > 0 && cyc == eq[0].cyc) begin
        n_checks++;
        if (smp_valid !== 1'b1 || smp_out !== eq[0].d) begin
          n_fails++;
          $display("FAIL %s/R6 cyc %0d: valid=%b out=%h expected valid=1 out=%h",
                   eq[0].tag, cyc, smp_valid, smp_out, eq[0].d);
        end
        void'(eq.pop_front());
      end else if (smp_valid !== 1'b0) begin
        n_checks++;
        n_fails++;
        $display("FAIL R6/R8 cyc %0d: valid=%b expected 0 (no frame due)", cyc, smp_valid);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not end, actual cyc %0d expected < 150000", cyc);
    finish_run();
  end

  task automatic check_reset(input string where);
    n_checks++;
    if (smp_valid !== 1'b0 || smp_out !== '0) begin
      n_fails++;
      $display("FAIL R1 %s: valid=%b out=%h expected valid=0 out=0", where, smp_valid, smp_out);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n   = 1'b0;
    fsync   = 1'b0;
    sdata   = 2'b00;
    src_sel = 3'd0;
    repeat (3) @(negedge clk);
    check_reset("in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset("after release");
    mon_on = 1'b1;

    // R2: low byte varies, upper bits distinct per slot
    for (int l = 0; l < 2; l++)
      for (int s = 0; s < 16; s++)
        fd[l][s] = {8'(l * 16 + s), 16'hA5C3, 8'($urandom)};
    src_sel = 3'd0;
    pulse_fs();
    check_reset("before first frame");
    body(FRAME_BITS, 1'b1, FRAME_BITS - 1, 3'd1, "R2/R3/R5");

    // R3, R4, R5: every source code in turn, back-to-back (R9)
    for (int k = 1; k < 8; k++) begin
      fill_random();
      body(FRAME_BITS, 1'b1, FRAME_BITS - 1, 3'((k + 1) % 8),
           (k < 4) ? "R3/R5/R9" : "R4/R5/R9");
    end

    // R2: all-ones pad bytes against all-zero pad bytes
    for (int l = 0; l < 2; l++)
      for (int s = 0; s < 16; s++)
        fd[l][s] = {24'($urandom), (s % 2 == 0) ? 8'hFF : 8'h00};
    body(FRAME_BITS, 1'b1, FRAME_BITS - 1, 3'd5, "R2");

    // R7: code change mid-frame applies from the next frame
    fill_random();
    body(FRAME_BITS, 1'b1, 100, 3'd6, "R7");
    fill_random();
    body(FRAME_BITS, 1'b1, FRAME_BITS - 1, 3'd3, "R7 next frame");

    // R8: partial frame cut by an early sync rise
    fill_random();
    body(200, 1'b1, -1, 3'd0, "R8 partial");
    fill_random();
    body(FRAME_BITS, 1'b1, FRAME_BITS - 1, 3'd7, "R8 resync");
    fill_random();
    body(37, 1'b1, 10, 3'd2, "R8 partial");
    fill_random();
    body(FRAME_BITS, 1'b0, -1, 3'd0, "R8 resync");

    // R9: idle gap then a fresh start
    idle(41);
    src_sel = 3'd4;
    fill_random();
    pulse_fs();
    body(FRAME_BITS, 1'b1, FRAME_BITS - 1, 3'($urandom), "R9 after gap");

    // random frames
    for (int k = 0; k < 8; k++) begin
      fill_random();
      body(FRAME_BITS, 1'b1, (k % 3 == 0) ? int'($urandom % 512) : FRAME_BITS - 1,
           3'($urandom), "R3/R4/R5 random");
    end
    fill_random();
    body(FRAME_BITS, 1'b0, -1, 3'd0, "R3/R4/R5 random");

    idle(FRAME_BITS + 20);
    n_checks++;
    if (eq.size() != 0) begin
      n_fails++;
      $display("FAIL R6: %0d results never checked, expected 0", eq.size());
    end
    finish_run();
  end

endmodule